// File: doc/BRIEF.md
# Dual Wiper Register Command Engine

This block carries out the instruction that a two-wire serial front end has already received and acknowledged, on behalf of two 64-position digital potentiometers. Each pot owns a volatile 6-bit wiper register and four stored registers whose contents are modelled as nonvolatile cells. The wiper register drives a one-hot 64-bit tap select, so exactly one tap switch of that pot is closed at any time.

The front end presents single-cycle events: an instruction byte, a data byte, a stop condition and, for stepping, one pulse per serial clock high period together with the level of the data line. The engine reads or writes either register type, copies between the wiper and a stored register for one pot or both at once, and steps a wiper one tap at a time. A write into stored cells begins at the stop condition and holds `busy` for a programmable number of clock cycles. While `busy` is high every input event is dropped. A low `wp_n` at the stop blocks the write.

Top module: `dual_wiper_engine`

## Requirements
- R1: `tap0` and `tap1` always have exactly one bit set, at the index equal to that pot's wiper value.
- R2: While reset is low both wipers sit at tap 0, `busy` is 0 and `rd_data` is 0. Within four clock cycles of reset release, each wiper holds its stored register 0. Stored register r of pot p resets to (DR_INIT + 8*p + 3*r) mod 64.
- R3: The instruction byte is laid out as opcode[7:4], register index[3:2], bit 1 = 0, pot[0]. Opcode 1010 followed by a data byte loads data[5:0] into the wiper of the selected pot one cycle after the data byte. Data bits 7:6 are dropped and the other pot is unchanged.
- R4: Opcode 1001 (read wiper) and opcode 1011 (read stored register) place {2'b00, value} on `rd_data` one cycle after the instruction.
- R5: Opcode 1101 copies stored register [index] of the selected pot into its wiper one cycle after the instruction.
- R6: Opcode 0001 copies stored register [index] of each pot into that pot's wiper, both in the same cycle.
- R7: Opcode 1100 followed by a data byte stores data[5:0] into the selected stored register. `busy` rises on the cycle after the stop and stays high for exactly WR_CYCLES cycles. The new value is readable once `busy` falls.
- R8: Opcode 1110 stores the selected pot's wiper value into stored register [index] of that pot. Opcode 1000 stores both wipers into register [index] of their own pots. Both take effect at the following stop, with the same busy timing as R7.
- R9: If `wp_n` is low at the stop, no stored-register write takes place: `busy` stays 0 and the stored contents are unchanged.
- R10: While `busy` is high, instruction, data, stop and step events are ignored. Taps and `rd_data` do not change.
- R11: After opcode 0010, each step pulse moves the selected wiper one tap up when `step_up` is 1 and one tap down when it is 0. The wiper saturates at 63 and at 0.
- R12: Opcodes 0000, 0011 to 0111 and 1111, and any instruction byte with bit 1 set, change no wiper, no stored register and no busy state.
- R13: Stepping ends at stop. Step pulses outside stepping mode, and steps for the other pot, leave the wipers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wp_n | input | 1 | Write enable for stored registers; low blocks stored writes |
| cmd_valid | input | 1 | One-cycle strobe: acknowledged instruction byte |
| cmd_byte | input | 8 | Instruction byte |
| data_valid | input | 1 | One-cycle strobe: acknowledged data byte |
| data_byte | input | 8 | Data byte |
| stop | input | 1 | One-cycle strobe: stop condition seen |
| step_valid | input | 1 | One-cycle strobe: serial clock high pulse in stepping mode |
| step_up | input | 1 | Data line level for the step: 1 up, 0 down |
| rd_data | output | 8 | Read result |
| busy | output | 1 | Stored-register write in progress |
| tap0 | output | 64 | One-hot tap select, pot 0 |
| tap1 | output | 64 | One-hot tap select, pot 1 |

## Verification
Every wiper change, whether a load, a copy or a step, shows on the taps one clock after the event strobe. A read result shows on `rd_data` one clock after the instruction. The recall of stored register 0 lands within four clocks of reset release, after the two-stage reset synchronizer and one recall cycle. `busy` is first high on the clock after the stop, and the bench counts its high samples so it can compare them with exactly WR_CYCLES before it reads back the stored value. All stimulus is driven on the falling edge and all outputs are sampled on the next falling edge, so each check falls half a cycle after the rising edge that is due to produce its result.

// File: rtl/dwe_pkg.sv
package dwe_pkg;
  localparam int NPOT = 2;
  localparam int NREG = 4;
  localparam int RIW  = $clog2(NREG);
  localparam int PW   = $clog2(NPOT);

  // opcode values carried in instruction bits [7:4]
  localparam logic [3:0] OPC_RD_WIPER  = 4'b1001;
  localparam logic [3:0] OPC_WR_WIPER  = 4'b1010;
  localparam logic [3:0] OPC_RD_STORE  = 4'b1011;
  localparam logic [3:0] OPC_WR_STORE  = 4'b1100;
  localparam logic [3:0] OPC_LOAD_ONE  = 4'b1101;
  localparam logic [3:0] OPC_SAVE_ONE  = 4'b1110;
  localparam logic [3:0] OPC_LOAD_ALL  = 4'b0001;
  localparam logic [3:0] OPC_SAVE_ALL  = 4'b1000;
  localparam logic [3:0] OPC_STEP      = 4'b0010;

  typedef enum logic [2:0] {
    K_NONE, K_RD_WIPER, K_WR_WIPER, K_RD_STORE, K_WR_STORE, K_LOAD, K_SAVE, K_STEP
  } kind_e;

  typedef struct packed {
    kind_e          kind;
    logic           both;
    logic [RIW-1:0] ridx;
    logic [PW-1:0]  pot;
  } instr_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GET_WIPER, ST_GET_STORE, ST_ARMED, ST_STEP
  } seq_e;
endpackage

// File: rtl/dwe_decode.sv
module dwe_decode
  import dwe_pkg::*;
(
  input  logic [7:0] b_i,
  output instr_t     ins_o
);
  always_comb begin
    ins_o.kind = K_NONE;
    ins_o.both = 1'b0;
    ins_o.ridx = b_i[3:2];
    ins_o.pot  = b_i[0];
    if (!b_i[1]) begin
      case (b_i[7:4])
        OPC_RD_WIPER: ins_o.kind = K_RD_WIPER;
        OPC_WR_WIPER: ins_o.kind = K_WR_WIPER;
        OPC_RD_STORE: ins_o.kind = K_RD_STORE;
        OPC_WR_STORE: ins_o.kind = K_WR_STORE;
        OPC_LOAD_ONE: ins_o.kind = K_LOAD;
        OPC_SAVE_ONE: ins_o.kind = K_SAVE;
        OPC_LOAD_ALL: begin ins_o.kind = K_LOAD; ins_o.both = 1'b1; end
        OPC_SAVE_ALL: begin ins_o.kind = K_SAVE; ins_o.both = 1'b1; end
        OPC_STEP:     ins_o.kind = K_STEP;
        default:      ins_o.kind = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dwe_wiper.sv
module dwe_wiper #(
  parameter int WW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_en,
  input  logic [WW-1:0]        load_val,
  input  logic                 step_en,
  input  logic                 step_up,
  output logic [WW-1:0]        pos_o,
  output logic [(2**WW)-1:0]   tap_o
);
  localparam int          NT   = 2**WW;
  localparam logic [WW-1:0] TOPV = WW'(NT - 1);

  logic [WW-1:0] pos_q, pos_d;
  logic          pos_en;

  assign pos_en = load_en | step_en;

  always_comb begin
    pos_d = pos_q;
    if (load_en) begin
      pos_d = load_val;
    end else if (step_en) begin
      if (step_up) begin
        if (pos_q != TOPV) pos_d = pos_q + 1'b1;
      end else begin
        if (pos_q != '0) pos_d = pos_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (pos_en) pos_q <= pos_d;
  end

  assign pos_o = pos_q;

  for (genvar t = 0; t < NT; t++) begin : g_tap
    assign tap_o[t] = (pos_q == WW'(t));
  end
endmodule

// File: rtl/dwe_nv_bank.sv
module dwe_nv_bank
  import dwe_pkg::*;
#(
  parameter int WW        = 6,
  parameter int WR_CYCLES = 500000,
  parameter int DR_INIT   = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic [NPOT-1:0]                   wmask,
  input  logic [RIW-1:0]                    widx,
  input  logic [NPOT-1:0][WW-1:0]           wval,
  output logic [NPOT-1:0][NREG-1:0][WW-1:0] cells_o,
  output logic                              busy_o
);
  localparam int CW = (WR_CYCLES < 2) ? 1 : $clog2(WR_CYCLES);
  localparam int NT = 2**WW;

  logic                    busy_q, busy_d;
  logic [CW-1:0]           tmr_q, tmr_d;
  logic                    tmr_en, pend_ld, commit;
  logic [NPOT-1:0]         pmask_q;
  logic [RIW-1:0]          pidx_q;
  logic [NPOT-1:0][WW-1:0] pval_q;

  assign pend_ld = start & ~busy_q;
  assign tmr_en  = pend_ld | busy_q;

  always_comb begin
    busy_d = busy_q;
    tmr_d  = tmr_q;
    commit = 1'b0;
    if (pend_ld) begin
      busy_d = 1'b1;
      tmr_d  = CW'(WR_CYCLES - 1);
    end else if (busy_q) begin
      if (tmr_q == '0) begin
        busy_d = 1'b0;
        commit = 1'b1;
      end else begin
        tmr_d = tmr_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tmr_q  <= '0;
    end else if (tmr_en) begin
      busy_q <= busy_d;
      tmr_q  <= tmr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmask_q <= '0;
      pidx_q  <= '0;
      pval_q  <= '0;
    end else if (pend_ld) begin
      pmask_q <= wmask;
      pidx_q  <= widx;
      pval_q  <= wval;
    end
  end

  for (genvar p = 0; p < NPOT; p++) begin : g_pot
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic [WW-1:0] cell_q;
      logic          cell_en;
      assign cell_en = commit & pmask_q[p] & (pidx_q == RIW'(r));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cell_q <= WW'((DR_INIT + 8*p + 3*r) % NT);
        else if (cell_en) cell_q <= pval_q[p];
      end
      assign cells_o[p][r] = cell_q;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/dual_wiper_engine.sv
module dual_wiper_engine
  import dwe_pkg::*;
#(
  parameter int WW        = 6,
  parameter int WR_CYCLES = 500000,
  parameter int DR_INIT   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wp_n,
  input  logic               cmd_valid,
  input  logic [7:0]         cmd_byte,
  input  logic               data_valid,
  input  logic [7:0]         data_byte,
  input  logic               stop,
  input  logic               step_valid,
  input  logic               step_up,
  output logic [7:0]         rd_data,
  output logic               busy,
  output logic [(2**WW)-1:0] tap0,
  output logic [(2**WW)-1:0] tap1
);
  localparam int NT = 2**WW;

  // reset: asserted asynchronously, released through two flops
  logic rs1_q, rs2_q, core_rst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign core_rst_n = rs2_q;

  instr_t ins;
  dwe_decode u_dec (.b_i(cmd_byte), .ins_o(ins));

  logic [NPOT-1:0][WW-1:0]           wpos;
  logic [NPOT-1:0][NT-1:0]           taps;
  logic [NPOT-1:0]                   load_en, step_en;
  logic [NPOT-1:0][WW-1:0]           load_val;
  logic [NPOT-1:0][NREG-1:0][WW-1:0] cells;
  logic                              nv_busy, nv_start;

  seq_e                    st_q, st_d;
  logic [PW-1:0]           pot_q, pot_d;
  logic [RIW-1:0]          ridx_q, ridx_d;
  logic [NPOT-1:0]         amask_q, amask_d;
  logic [NPOT-1:0][WW-1:0] aval_q, aval_d;
  logic [7:0]              rd_q, rd_d;
  logic                    recall_q;
  logic                    ctl_en;

  assign ctl_en = ~nv_busy & ~recall_q;

  always_comb begin
    st_d     = st_q;
    pot_d    = pot_q;
    ridx_d   = ridx_q;
    amask_d  = amask_q;
    aval_d   = aval_q;
    rd_d     = rd_q;
    load_en  = '0;
    load_val = '0;
    step_en  = '0;
    nv_start = 1'b0;
    if (recall_q) begin
      for (int p = 0; p < NPOT; p++) begin
        load_en[p]  = 1'b1;
        load_val[p] = cells[p][0];
      end
    end else if (!nv_busy) begin
      if (cmd_valid) begin
        st_d   = ST_IDLE;
        pot_d  = ins.pot;
        ridx_d = ins.ridx;
        case (ins.kind)
          K_RD_WIPER: rd_d = {{(8-WW){1'b0}}, wpos[ins.pot]};
          K_RD_STORE: rd_d = {{(8-WW){1'b0}}, cells[ins.pot][ins.ridx]};
          K_WR_WIPER: st_d = ST_GET_WIPER;
          K_WR_STORE: st_d = ST_GET_STORE;
          K_LOAD: begin
            for (int p = 0; p < NPOT; p++) begin
              if (ins.both || ins.pot == PW'(p)) begin
                load_en[p]  = 1'b1;
                load_val[p] = cells[p][ins.ridx];
              end
            end
          end
          K_SAVE: begin
            st_d   = ST_ARMED;
            aval_d = wpos;
            for (int p = 0; p < NPOT; p++) begin
              amask_d[p] = ins.both || (ins.pot == PW'(p));
            end
          end
          K_STEP:  st_d = ST_STEP;
          default: st_d = ST_IDLE;
        endcase
      end else if (data_valid) begin
        if (st_q == ST_GET_WIPER) begin
          load_en[pot_q]  = 1'b1;
          load_val[pot_q] = data_byte[WW-1:0];
          st_d            = ST_IDLE;
        end else if (st_q == ST_GET_STORE) begin
          amask_d        = '0;
          amask_d[pot_q] = 1'b1;
          aval_d[pot_q]  = data_byte[WW-1:0];
          st_d           = ST_ARMED;
        end
      end else if (stop) begin
        nv_start = (st_q == ST_ARMED) && wp_n;
        st_d     = ST_IDLE;
      end else if (step_valid && st_q == ST_STEP) begin
        step_en[pot_q] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      st_q    <= ST_IDLE;
      pot_q   <= '0;
      ridx_q  <= '0;
      amask_q <= '0;
      aval_q  <= '0;
      rd_q    <= '0;
    end else if (ctl_en) begin
      st_q    <= st_d;
      pot_q   <= pot_d;
      ridx_q  <= ridx_d;
      amask_q <= amask_d;
      aval_q  <= aval_d;
      rd_q    <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) recall_q <= 1'b1;
    else             recall_q <= 1'b0;
  end

  for (genvar p = 0; p < NPOT; p++) begin : g_wiper
    dwe_wiper #(.WW(WW)) u_wiper (
      .clk      (clk),
      .rst_n    (core_rst_n),
      .load_en  (load_en[p]),
      .load_val (load_val[p]),
      .step_en  (step_en[p]),
      .step_up  (step_up),
      .pos_o    (wpos[p]),
      .tap_o    (taps[p])
    );
  end

  dwe_nv_bank #(.WW(WW), .WR_CYCLES(WR_CYCLES), .DR_INIT(DR_INIT)) u_bank (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .start   (nv_start),
    .wmask   (amask_q),
    .widx    (ridx_q),
    .wval    (aval_q),
    .cells_o (cells),
    .busy_o  (nv_busy)
  );

  assign rd_data = rd_q;
  assign busy    = nv_busy;
  assign tap0    = taps[0];
  assign tap1    = taps[1];
endmodule

// File: rtl/dwe_chk.sv
module dwe_chk #(
  parameter int WW = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wp_n,
  input logic               cmd_valid,
  input logic               data_valid,
  input logic               stop,
  input logic               step_valid,
  input logic               step_up,
  input logic [7:0]         rd_data,
  input logic               busy,
  input logic [(2**WW)-1:0] tap0,
  input logic [(2**WW)-1:0] tap1
);
  localparam int NT = 2**WW;

  // R1
  tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tap0) == 1) && ($countones(tap1) == 1));

  // R7
  busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop));

  // R9
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !wp_n && !busy) |=> !busy);

  // R10
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(tap0) && $stable(tap1) && $stable(rd_data)));

  // R11
  top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tap0[NT-1] && step_valid && step_up && !cmd_valid && !data_valid) |=> tap0[NT-1]);

  // R11
  bot_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tap1[0] && step_valid && !step_up && !cmd_valid && !data_valid) |=> tap1[0]);
endmodule

bind dual_wiper_engine dwe_chk #(.WW(WW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wp_n       (wp_n),
  .cmd_valid  (cmd_valid),
  .data_valid (data_valid),
  .stop       (stop),
  .step_valid (step_valid),
  .step_up    (step_up),
  .rd_data    (rd_data),
  .busy       (busy),
  .tap0       (tap0),
  .tap1       (tap1)
);

// File: tb/dual_wiper_engine_tb.sv
module dual_wiper_engine_tb;
  localparam int WRC   = 8;
  localparam int DINIT = 32;

  logic        clk = 1'b0;
  logic        rst_n, wp_n, cmd_valid, data_valid, stop, step_valid, step_up;
  logic [7:0]  cmd_byte, data_byte, rd_data;
  logic        busy;
  logic [63:0] tap0, tap1;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int m_wcr [2];
  int m_dr  [2][4];

  always #5 clk = ~clk;

  dual_wiper_engine #(.WW(6), .WR_CYCLES(WRC), .DR_INIT(DINIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .data_valid(data_valid), .data_byte(data_byte), .stop(stop), .step_valid(step_valid),
    .step_up(step_up), .rd_data(rd_data), .busy(busy), .tap0(tap0), .tap1(tap1)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_taps(input string tag);
    chk(tag, tap0, 64'd1 << m_wcr[0]);
    chk(tag, tap1, 64'd1 << m_wcr[1]);
  endtask

  task automatic put_cmd(input logic [7:0] b);
    cmd_byte = b; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic put_data(input logic [7:0] b);
    data_byte = b; data_valid = 1'b1;
    @(negedge clk); data_valid = 1'b0;
  endtask

  task automatic put_stop();
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic put_step(input logic up);
    step_up = up; step_valid = 1'b1;
    @(negedge clk); step_valid = 1'b0;
  endtask

  // returns the number of sampled busy cycles
  task automatic wait_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  function automatic logic [7:0] ib(input logic [3:0] op, input int r, input int p);
    return {op, 2'(r), 1'b0, 1'(p)};
  endfunction

  task automatic read_store(input string tag, input int p, input int r);
    put_cmd(ib(4'b1011, r, p));
    chk(tag, {56'd0, rd_data}, 64'(m_dr[p][r]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; wp_n = 1'b1; cmd_valid = 0; data_valid = 0; stop = 0;
    step_valid = 0; step_up = 0; cmd_byte = 0; data_byte = 0;
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 4; r++) m_dr[p][r] = (DINIT + 8*p + 3*r) % 64;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 tap0 in reset", tap0, 64'd1);
    chk("R2 tap1 in reset", tap1, 64'd1);
    chk("R2 busy in reset", {63'd0, busy}, 64'd0);
    chk("R2 rd_data in reset", {56'd0, rd_data}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_wcr[0] = m_dr[0][0]; m_wcr[1] = m_dr[1][0];
    chk_taps("R2 recall of stored reg 0");

    // R3 / R1 sweep of every wiper value, upper data bits set
    for (int p = 0; p < 2; p++) begin
      for (int v = 0; v < 64; v++) begin
        put_cmd(ib(4'b1010, 0, p));
        put_data({2'(v), 6'(v)});
        m_wcr[p] = v;
        chk_taps("R3 R1 wiper write");
      end
    end

    // R4 reads
    m_wcr[0] = 17; m_wcr[1] = 44;
    put_cmd(ib(4'b1010, 0, 0)); put_data(8'hD1);
    put_cmd(ib(4'b1010, 0, 1)); put_data(8'h2C);
    for (int p = 0; p < 2; p++) begin
      put_cmd(ib(4'b1001, 0, p));
      chk("R4 read wiper", {56'd0, rd_data}, 64'(m_wcr[p]));
      for (int r = 0; r < 4; r++) read_store("R4 read stored", p, r);
    end

    // R7 stored writes with busy length
    for (int p = 0; p < 2; p++) begin
      for (int r = 0; r < 4; r++) begin
        int v;
        v = (p*16 + r*5 + 7) % 64;
        put_cmd(ib(4'b1100, r, p));
        put_data({2'b11, 6'(v)});
        put_stop();
        wait_busy(n);
        chk("R7 busy length", 64'(n), 64'(WRC));
        m_dr[p][r] = v;
        read_store("R7 stored readback", p, r);
      end
    end

    // R5 single-pot copy stored -> wiper
    for (int p = 0; p < 2; p++) begin
      for (int r = 0; r < 4; r++) begin
        put_cmd(ib(4'b1101, r, p));
        m_wcr[p] = m_dr[p][r];
        chk_taps("R5 single copy to wiper");
      end
    end

    // R6 global copy
    for (int r = 3; r >= 0; r--) begin
      put_cmd(ib(4'b0001, r, 0));
      m_wcr[0] = m_dr[0][r]; m_wcr[1] = m_dr[1][r];
      chk_taps("R6 global copy to wiper");
    end

    // R8 save one pot, then both
    put_cmd(ib(4'b1010, 0, 0)); put_data(8'd11); m_wcr[0] = 11;
    put_cmd(ib(4'b1010, 0, 1)); put_data(8'd22); m_wcr[1] = 22;
    put_cmd(ib(4'b1110, 2, 0)); put_stop();
    wait_busy(n);
    chk("R8 save busy length", 64'(n), 64'(WRC));
    m_dr[0][2] = 11;
    read_store("R8 saved pot0", 0, 2);
    read_store("R8 pot1 untouched", 1, 2);
    put_cmd(ib(4'b1000, 3, 0)); put_stop();
    wait_busy(n);
    m_dr[0][3] = 11; m_dr[1][3] = 22;
    read_store("R8 global save pot0", 0, 3);
    read_store("R8 global save pot1", 1, 3);

    // R9 write protect
    wp_n = 1'b0;
    put_cmd(ib(4'b1100, 1, 1)); put_data(8'd63); put_stop();
    chk("R9 no busy when protected", {63'd0, busy}, 64'd0);
    wp_n = 1'b1;
    read_store("R9 stored unchanged", 1, 1);
    put_cmd(ib(4'b1110, 0, 0)); wp_n = 1'b0; put_stop(); wp_n = 1'b1;
    chk("R9 no busy on save", {63'd0, busy}, 64'd0);
    read_store("R9 save blocked", 0, 0);

    // R10 ignore while busy
    put_cmd(ib(4'b1100, 0, 1)); put_data(8'd5); put_stop();
    chk("R10 busy raised", {63'd0, busy}, 64'd1);
    put_cmd(ib(4'b1010, 0, 0)); put_data(8'd50);
    put_cmd(ib(4'b1001, 0, 1));
    chk_taps("R10 taps frozen");
    wait_busy(n);
    m_dr[1][0] = 5;
    chk_taps("R10 taps after busy");
    read_store("R10 write still landed", 1, 0);

    // R11 / R13 stepping
    put_cmd(ib(4'b1010, 0, 0)); put_data(8'd60); m_wcr[0] = 60;
    put_cmd(ib(4'b0010, 0, 0));
    for (int i = 0; i < 6; i++) begin
      put_step(1'b1);
      if (m_wcr[0] < 63) m_wcr[0]++;
      chk_taps("R11 step up saturate");
    end
    put_step(1'b0); m_wcr[0] = 62;
    chk_taps("R11 step down");
    put_stop();
    chk("R13 no busy after step stop", {63'd0, busy}, 64'd0);
    put_step(1'b1);
    chk_taps("R13 step after stop ignored");
    put_cmd(ib(4'b1010, 0, 1)); put_data(8'd2); m_wcr[1] = 2;
    put_cmd(ib(4'b0010, 0, 1));
    for (int i = 0; i < 4; i++) begin
      put_step(1'b0);
      if (m_wcr[1] > 0) m_wcr[1]--;
      chk_taps("R11 step down saturate");
    end
    put_step(1'b1); m_wcr[1] = 1;
    chk_taps("R13 only selected pot moves");
    put_stop();

    // R12 unused opcodes and bit 1 set
    for (int op = 0; op < 16; op++) begin
      if (op == 0 || (op >= 3 && op <= 7) || op == 15) begin
        put_cmd({4'(op), 4'b0100});
        put_data(8'h15); put_stop(); put_step(1'b1);
        chk_taps("R12 unused opcode");
        chk("R12 no busy", {63'd0, busy}, 64'd0);
      end
    end
    put_cmd(8'hA2); put_data(8'h30); put_stop();
    chk_taps("R12 bit1 set wiper write");
    put_cmd(8'hC6); put_data(8'h30); put_stop();
    chk("R12 bit1 set store write", {63'd0, busy}, 64'd0);
    read_store("R12 stored unchanged", 0, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule